// File: doc/BRIEF.md
# Command-Triggered Auxiliary Output Timer

This block drives four auxiliary strobes of a DDR2/DDR3 memory PHY, the usual use being on-die termination control. Each strobe is timed from single-cycle read and write command pulses. For every strobe, a programmable delay sets how many memory clock cycles after the command the strobe rises, and a programmable length sets how many cycles it stays high. Read and write commands each have their own delay and length. Software picks these values so that the termination window meets the DRAM's turn-on and turn-off latencies.

Each strobe also has a bit in a force mask. While the calibration write-leveling flag is high, every strobe whose force bit is set is held high, whatever its timer is doing. Timing values and the mask are static configuration. They must not change while commands are in flight.

Top module: `aux_out_timer`

## Requirements
- R1: After reset is released, and until a command or a force arrives, all four bits of `aux_o` are 0.
- R2: A write command sampled at clock edge k, with write delay N and length D on strobe i, drives `aux_o[i]` high after edges k+N through k+N+D-1 and low after edge k+N+D.
- R3: A delay of 0 raises the strobe right after the edge that samples the command.
- R4: A length of 0 produces no pulse on that strobe.
- R5: A read command uses the strobe's read delay and read length in the same way as R2.
- R6: When read and write are sampled at the same edge, only the write timing is applied.
- R7: A new command restarts the strobe's timer. A strobe that is high when the new command arrives stays high through the new delay and then for the new length. A pending, not yet started pulse is replaced by the new one.
- R8: While `wrlvl_i` is high at edge k, every strobe whose bit in `wl_en_i` is 1 is high after edge k. A strobe whose bit is 0 is not affected by `wrlvl_i`.
- R9: Each strobe i uses only its own field: bits [6i+5:6i] of each timing vector. Strobes do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_cmd_i | input | 1 | Write command strobe, one cycle per command |
| rd_cmd_i | input | 1 | Read command strobe, one cycle per command |
| wrlvl_i | input | 1 | Calibration write-leveling flag |
| wl_en_i | input | 4 | Per-strobe force mask used during write leveling |
| wr_off_i | input | 24 | Write delays, 6 bits per strobe |
| wr_dur_i | input | 24 | Write lengths, 6 bits per strobe |
| rd_off_i | input | 24 | Read delays, 6 bits per strobe |
| rd_dur_i | input | 24 | Read lengths, 6 bits per strobe |
| aux_o | output | 4 | Registered auxiliary strobes |

## Verification
A wrong delay or length counter shows up at the port as a strobe edge that is off by a cycle or more. The bench compares every strobe, cycle by cycle, over a 16-cycle window that starts at the sampling edge, so the error is caught in the cycle it happens. Faults in command priority or restart logic show up as a whole window of the wrong shape: a read-shaped pulse where a write was due, a gap in a bridged pulse, or a stale pulse that should have been replaced. A broken force path is seen one edge after `wrlvl_i` rises.

// File: rtl/aux_timer_pkg.sv
package aux_timer_pkg;
  localparam int unsigned N_AUX = 4;
  localparam int unsigned CNT_W = 6;

  typedef struct packed {
    logic [CNT_W-1:0] off;
    logic [CNT_W-1:0] dur;
  } aux_timing_t;
endpackage

// File: rtl/aux_cmd_sel.sv
module aux_cmd_sel #(
  parameter int unsigned CW = 6
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [CW-1:0] wr_off_i,
  input  logic [CW-1:0] wr_dur_i,
  input  logic [CW-1:0] rd_off_i,
  input  logic [CW-1:0] rd_dur_i,
  output logic          cmd_o,
  output logic [CW-1:0] off_o,
  output logic [CW-1:0] dur_o
);
  // write wins on a same-cycle collision
  always_comb begin
    cmd_o = wr_i | rd_i;
    off_o = wr_i ? wr_off_i : rd_off_i;
    dur_o = wr_i ? wr_dur_i : rd_dur_i;
  end
endmodule

// File: rtl/aux_chan_timer.sv
module aux_chan_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] dur_i,
  input  logic          force_i,
  output logic          aux_o
);
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] ZERO = '0;

  logic          pend_q, pend_d;
  logic          act_q, act_d;
  logic          aux_q;
  logic [CW-1:0] dly_q, dly_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] load_q, load_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    dly_d  = dly_q;
    len_d  = len_q;
    load_d = load_q;
    if (cmd_i) begin
      if (off_i == ZERO) begin
        pend_d = 1'b0;
        act_d  = (dur_i != ZERO);
        len_d  = dur_i - ONE;
      end else begin
        // active pulse is held while the new delay runs
        pend_d = 1'b1;
        dly_d  = off_i - ONE;
        load_d = dur_i;
      end
    end else if (pend_q) begin
      if (dly_q == ZERO) begin
        pend_d = 1'b0;
        act_d  = (load_q != ZERO);
        len_d  = load_q - ONE;
      end else begin
        dly_d = dly_q - ONE;
      end
    end else if (act_q) begin
      if (len_q == ZERO) act_d = 1'b0;
      else               len_d = len_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      aux_q  <= 1'b0;
      dly_q  <= '0;
      len_q  <= '0;
      load_q <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      aux_q  <= act_d | force_i;
      dly_q  <= dly_d;
      len_q  <= len_d;
      load_q <= load_d;
    end
  end

  assign aux_o = aux_q;

  a_r3_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i && off_i == ZERO && dur_i != ZERO |=> act_q);
  a_r4_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i && off_i == ZERO && dur_i == ZERO |=> !act_q);
  a_r7_bridge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && pend_q && !cmd_i && dly_q != ZERO |=> act_q);
  a_r8_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> aux_o);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !act_q && !cmd_i && !force_i |=> !aux_o);
endmodule

// File: rtl/aux_out_timer.sv
module aux_out_timer
  import aux_timer_pkg::*;
#(
  parameter int unsigned NA = N_AUX,
  parameter int unsigned CW = CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_cmd_i,
  input  logic           rd_cmd_i,
  input  logic           wrlvl_i,
  input  logic [NA-1:0]  wl_en_i,
  input  logic [NA*CW-1:0] wr_off_i,
  input  logic [NA*CW-1:0] wr_dur_i,
  input  logic [NA*CW-1:0] rd_off_i,
  input  logic [NA*CW-1:0] rd_dur_i,
  output logic [NA-1:0]  aux_o
);
  for (genvar i = 0; i < NA; i++) begin : g_ch
    logic          cmd;
    logic [CW-1:0] off, dur;

    aux_cmd_sel #(.CW(CW)) u_sel (
      .wr_i     (wr_cmd_i),
      .rd_i     (rd_cmd_i),
      .wr_off_i (wr_off_i[i*CW +: CW]),
      .wr_dur_i (wr_dur_i[i*CW +: CW]),
      .rd_off_i (rd_off_i[i*CW +: CW]),
      .rd_dur_i (rd_dur_i[i*CW +: CW]),
      .cmd_o    (cmd),
      .off_o    (off),
      .dur_o    (dur)
    );

    aux_chan_timer #(.CW(CW)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_i   (cmd),
      .off_i   (off),
      .dur_i   (dur),
      .force_i (wrlvl_i & wl_en_i[i]),
      .aux_o   (aux_o[i])
    );
  end
endmodule

// File: tb/aux_out_timer_tb.sv
module aux_out_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, wrlvl = 1'b0;
  logic [3:0]  wl_en = '0;
  logic [23:0] wr_off, wr_dur, rd_off, rd_dur;
  logic [3:0]  aux;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  aux_out_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_cmd_i(wr), .rd_cmd_i(rd),
    .wrlvl_i(wrlvl), .wl_en_i(wl_en), .wr_off_i(wr_off), .wr_dur_i(wr_dur),
    .rd_off_i(rd_off), .rd_dur_i(rd_dur), .aux_o(aux));

  // per strobe: wr(off,dur) rd(off,dur)
  localparam int WO[4] = '{3, 0, 2, 6};
  localparam int WD[4] = '{4, 2, 0, 1};
  localparam int RO[4] = '{1, 5, 0, 2};
  localparam int RD[4] = '{2, 3, 0, 5};

  function automatic logic [15:0] win(int off, int dur);
    return 16'(((32'd1 << dur) - 1) << off);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, int m);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: aux=%b expected %b", req, m, act, exp);
    end
  endtask

  // cmd driven at negedge, sampled at edge k; sample m is after edge k+m
  task automatic run_cmd(string req, bit w, bit r, logic [15:0] exp[4]);
    @(negedge clk); wr = w; rd = r;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); wr = 0; rd = 0;
      check(req, aux, {exp[3][m], exp[2][m], exp[1][m], exp[0][m]}, m);
    end
  endtask

  task automatic t_reset();
    for (int m = 0; m < 3; m++) begin
      @(negedge clk); check("R1", aux, 4'b0000, m);
    end
  endtask

  task automatic t_write();  // R2 R3 R4 R9
    logic [15:0] e[4];
    for (int i = 0; i < 4; i++) e[i] = win(WO[i], WD[i]);
    run_cmd("R2", 1, 0, e);
  endtask

  task automatic t_read();   // R5 R4 R9
    logic [15:0] e[4];
    for (int i = 0; i < 4; i++) e[i] = win(RO[i], RD[i]);
    run_cmd("R5", 0, 1, e);
  endtask

  task automatic t_both();   // R6
    logic [15:0] e[4];
    for (int i = 0; i < 4; i++) e[i] = win(WO[i], WD[i]);
    run_cmd("R6", 1, 1, e);
  endtask

  task automatic t_restart(); // R7: second write sampled at edge k+4
    logic [15:0] e[4];
    e[0] = win(3, 8);                 // bridged 3..10
    e[1] = win(0, 2) | win(4, 2);
    e[2] = '0;
    e[3] = win(10, 1);                // pending pulse replaced
    @(negedge clk); wr = 1;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); wr = (m == 3);
      check("R7", aux, {e[3][m], e[2][m], e[1][m], e[0][m]}, m);
    end
  endtask

  task automatic t_wl();     // R8
    @(negedge clk); wl_en = 4'b0101; wrlvl = 1;
    for (int m = 0; m < 3; m++) begin
      @(negedge clk); check("R8", aux, 4'b0101, m);
    end
    wrlvl = 0;
    @(negedge clk); check("R8", aux, 4'b0000, 3);
    wl_en = 4'b0000; wrlvl = 1;
    for (int m = 4; m < 6; m++) begin
      @(negedge clk); check("R8", aux, 4'b0000, m);
    end
    wrlvl = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      wr_off[i*6 +: 6] = 6'(WO[i]); wr_dur[i*6 +: 6] = 6'(WD[i]);
      rd_off[i*6 +: 6] = 6'(RO[i]); rd_dur[i*6 +: 6] = 6'(RD[i]);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_write();
    t_read();
    t_both();
    t_restart();
    t_wl();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule